// File: doc/BRIEF.md
# Synchronous Gated Power-of-Two Clock Divider

This block takes a single input clock and produces three divided clocks running at one half, one quarter and one eighth of the input rate. All three come from one binary counter clocked by a single internal clock, so whenever two or more outputs switch on the same input cycle they switch on the same rising edge.

An active-high hold input freezes the divider without losing its phase. The hold level is captured on the falling input edge, and the captured value gates the internal clock. Because the gate changes only while the input clock is low, the counter never sees a shortened pulse. An active-high reset clears the divider so that several instances can be lined up. Reset release is aligned through a falling-edge stage and then a rising-edge stage, which gives a fixed and predictable delay to the first output edge.

Top module: `pow2_clk_divider`

## Requirements
- R1: While `rst_i` is high, `div_o` reads 3'b000 without waiting for a clock edge, and the captured hold state is cleared to "running".
- R2: `div_o` forms a 3-bit binary up-count that advances by one on each counted rising edge. Bit 0 divides the input by 2, bit 1 by 4 and bit 2 by 8. The first count after reset sets `div_o` to 3'b001.
- R3: Bit i of `div_o` changes only on a rising edge where every lower bit also changes.
- R4: `hold_i` is sampled on the falling edge of `clk_i`. A high sample blocks every following rising edge from changing `div_o` until a low sample is taken. A hold raised after a falling edge does not stop the rising edge that comes next.
- R5: The internal gated clock switches between running and stopped only while `clk_i` is low.
- R6: After a low `hold_i` is sampled on a falling edge, the next rising edge advances `div_o` by exactly one from its frozen value.
- R7: If `rst_i` falls while `clk_i` is high, the second rising edge after the release is the first edge that changes `div_o`.
- R8: If `rst_i` falls while `clk_i` is low, the third rising edge after the release is the first edge that changes `div_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Active-high reset; asserts asynchronously and is aligned on release |
| hold_i | input | 1 | Active-high freeze request, sampled on the falling edge |
| div_o | output | 3 | Divided clocks: bit 0 at /2, bit 1 at /4, bit 2 at /8 |

## Verification
The bench releases reset once during the high phase and once during the low phase of the clock. It counts the rising edges until the first output change. A wrong alignment stage would move the first edge by a cycle, or make both cases take the same time. The bench raises hold both just before and just after a falling edge. A design that sampled hold on the rising edge, or gated the clock without registering hold, would freeze one cycle early or late. After resuming, it would then skip a count or repeat one. The bench also measures each output period and checks that edges coincide. A counter built from rippled stages, or one that loses phase across a freeze, would show skewed edges or a wrong period.

// File: rtl/p2div_pkg.sv
package p2div_pkg;

    // Default number of divider stages (outputs at /2, /4, ... /2^N)
    localparam int DEF_STAGES = 3;

    // Control bundle produced by the edge-aligned front end
    typedef struct packed {
        logic run;    // gated clock allowed to pulse
        logic armed;  // reset release has completed its alignment
    } gate_ctrl_t;

    // Division ratio of a given output stage
    function automatic int ratio_of(input int stage);
        return 2 << stage;
    endfunction

endpackage

// File: rtl/p2div_hold_sampler.sv
module p2div_hold_sampler (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic run_q
);
    // Captured on the falling edge so the gate only moves during the low phase
    always_ff @(negedge clk or posedge rst) begin
        if (rst) run_q <= 1'b1;
        else     run_q <= ~hold;
    end
endmodule

// File: rtl/p2div_clk_gate.sv
module p2div_clk_gate (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic gclk
);
    assign gclk = clk & run;

    // R5: the enable of the AND gate may only move while the input clock is low
    always @(run) begin
        if (!rst) begin
            a_r5_gate_moves_low: assert (clk == 1'b0)
                else $error("gate enable changed while clock high");
        end
    end
endmodule

// File: rtl/p2div_release_align.sv
module p2div_release_align (
    input  logic clk,
    input  logic rst,
    output logic armed
);
    logic fall_q;
    logic rise_q;

    always_ff @(negedge clk or posedge rst) begin
        if (rst) fall_q <= 1'b1;
        else     fall_q <= 1'b0;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) rise_q <= 1'b1;
        else     rise_q <= fall_q;
    end

    assign armed = ~rise_q;
endmodule

// File: rtl/p2div_counter.sv
module p2div_counter #(
    parameter int STAGES = p2div_pkg::DEF_STAGES
) (
    input  logic              gclk,
    input  logic              rst,
    input  logic              armed,
    output logic [STAGES-1:0] cnt_o
);
    logic [STAGES:0] carry;

    assign carry[0] = armed;

    // One toggle stage per output; every stage shares the same clock edge
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic bit_q;
        always_ff @(posedge gclk or posedge rst) begin
            if (rst)           bit_q <= 1'b0;
            else if (carry[i]) bit_q <= ~bit_q;
        end
        assign carry[i+1] = carry[i] & bit_q;
        assign cnt_o[i]   = bit_q;
    end
endmodule

// File: rtl/pow2_clk_divider.sv
module pow2_clk_divider #(
    parameter int NUM_DIV = p2div_pkg::DEF_STAGES
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               hold_i,
    output logic [NUM_DIV-1:0] div_o
);
    import p2div_pkg::*;

    localparam int LAST_RATIO = ratio_of(NUM_DIV - 1);

    gate_ctrl_t ctrl;
    logic       gclk;

    p2div_hold_sampler u_hold (
        .clk   (clk_i),
        .rst   (rst_i),
        .hold  (hold_i),
        .run_q (ctrl.run)
    );

    p2div_release_align u_rel (
        .clk   (clk_i),
        .rst   (rst_i),
        .armed (ctrl.armed)
    );

    p2div_clk_gate u_gate (
        .clk  (clk_i),
        .rst  (rst_i),
        .run  (ctrl.run),
        .gclk (gclk)
    );

    p2div_counter #(.STAGES(NUM_DIV)) u_cnt (
        .gclk  (gclk),
        .rst   (rst_i),
        .armed (ctrl.armed),
        .cnt_o (div_o)
    );

    // R1: outputs are cleared whenever reset is high
    always @(negedge clk_i) begin
        if (rst_i) begin
            a_r1_reset_clear: assert (div_o == '0)
                else $error("outputs not cleared in reset (last ratio %0d)", LAST_RATIO);
        end
    end

    // R2 / R6: a running, armed cycle advances the count by one
    a_r2_count_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl.run && ctrl.armed) |=> (div_o == $past(div_o) + NUM_DIV'(1)))
        else $error("count did not advance by one");

    // R4: a sampled hold freezes the outputs
    a_r4_freeze: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ctrl.run) |=> $stable(div_o))
        else $error("outputs moved during hold");

    // R7 / R8: no count until the release alignment completes
    a_r7_release_wait: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ctrl.armed) |=> $stable(div_o))
        else $error("count moved before release alignment");

    // R3: a higher stage only switches together with every lower stage
    for (genvar i = 1; i < NUM_DIV; i++) begin : g_align
        a_r3_aligned: assert property (@(posedge clk_i) disable iff (rst_i)
            (div_o[i] != $past(div_o[i])) |-> (div_o[i-1] != $past(div_o[i-1])))
            else $error("stage %0d switched without lower stage", i);
    end

endmodule

// File: tb/pow2_clk_divider_bench.sv
module pow2_clk_divider_bench;

    logic       clk  = 1'b0;
    logic       rst  = 1'b1;
    logic       hold = 1'b0;
    logic [2:0] div;

    int    checks = 0;
    int    fails  = 0;
    string phase_tag = "R1";

    // Reference model state
    int    exp_cnt = 0;
    int    wait_e  = 0;
    logic  hold_s  = 1'b0;
    int    exp_q[$];
    logic [2:0] prev_div = 3'b000;
    bit    prev_ok = 1'b0;

    always #2 clk = ~clk;

    pow2_clk_divider u_pow2_clk_divider (
        .clk_i  (clk),
        .rst_i  (rst),
        .hold_i (hold),
        .div_o  (div)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Model: hold captured on falling edge (R4), cleared by reset (R1)
    always @(negedge clk or posedge rst) begin
        if (rst) hold_s <= 1'b0;
        else     hold_s <= hold;
    end

    // Model: release latency depends on clock level at release (R7, R8)
    always @(negedge rst) wait_e = clk ? 2 : 3;

    // Driver side of the scoreboard: one expected value per rising edge
    always @(posedge clk) begin
        if (rst) exp_cnt = 0;
        else if (wait_e > 1) wait_e--;
        else begin
            wait_e = 0;
            if (!hold_s) exp_cnt = (exp_cnt + 1) % 8;
        end
        exp_q.push_back(exp_cnt);
    end

    // Monitor side: compare mid-cycle, away from the active edge
    always @(negedge clk) begin
        int e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            if (rst) e = 0;
            check(div == 3'(e), phase_tag, int'(div), e);
        end
        if (!rst && prev_ok) begin
            // R3 coincident edges
            if (div[2] != prev_div[2])
                check(div[1] != prev_div[1] && div[0] != prev_div[0], "R3", int'(div), int'(prev_div));
            if (div[1] != prev_div[1])
                check(div[0] != prev_div[0], "R3", int'(div), int'(prev_div));
        end
        prev_div = div;
        prev_ok  = !rst;
    end

    task automatic first_edge(input int expect_n, input string req);
        int n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while (div == 3'b000 && n < 10);
        check(n == expect_n, req, n, expect_n);
        check(div == 3'b001, "R2", int'(div), 1);
    endtask

    task automatic period_check(input int b, input int expect_p);
        logic p;
        int   n = 0;
        do begin
            p = div[b];
            @(posedge clk); #1;
        end while (!(p == 1'b0 && div[b] == 1'b1));
        do begin
            p = div[b];
            @(posedge clk); #1;
            n++;
        end while (!(p == 1'b0 && div[b] == 1'b1));
        check(n == expect_p, "R2", n, expect_p);
    endtask

    initial begin
        logic [2:0] v;
        // Reset state
        repeat (3) @(posedge clk);
        #1;
        check(div == 3'b000, "R1", int'(div), 0);

        // R7: release during the high phase
        phase_tag = "R7";
        rst = 1'b0;
        first_edge(2, "R7");

        // R2: periods of each output
        phase_tag = "R2";
        period_check(0, 2);
        period_check(1, 4);
        period_check(2, 8);

        // R1: asynchronous clear in the high phase
        phase_tag = "R1";
        @(posedge clk); #0.5;
        rst = 1'b1;
        #0.5;
        check(div == 3'b000, "R1", int'(div), 0);
        repeat (3) @(posedge clk);

        // R8: release during the low phase
        phase_tag = "R8";
        @(negedge clk); #1;
        rst = 1'b0;
        first_edge(3, "R8");

        // R4: hold raised in the high phase freezes from the next rising edge
        phase_tag = "R4";
        repeat (3) @(posedge clk);
        #1;
        v = div;
        hold = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        check(div == v, "R4", int'(div), int'(v));

        // R6: resume steps by exactly one
        phase_tag = "R6";
        hold = 1'b0;
        @(posedge clk); #1;
        check(div == v + 3'd1, "R6", int'(div), int'(v + 3'd1));

        // R4: hold raised after a falling edge lets the next rising edge count
        phase_tag = "R4";
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        v = div;
        hold = 1'b1;
        @(posedge clk); #1;
        check(div == v + 3'd1, "R4", int'(div), int'(v + 3'd1));
        repeat (4) @(posedge clk);
        #1;
        check(div == v + 3'd1, "R4", int'(div), int'(v + 3'd1));

        // R6: release hold in the low phase; takes effect one falling edge later
        phase_tag = "R6";
        @(negedge clk); #1;
        hold = 1'b0;
        @(posedge clk); #1;
        check(div == v + 3'd1, "R6", int'(div), int'(v + 3'd1));
        @(posedge clk); #1;
        check(div == v + 3'd2, "R6", int'(div), int'(v + 3'd2));

        // R1: hold state cleared by reset, R5 gate observed via counting
        phase_tag = "R1";
        hold = 1'b1;
        @(posedge clk); #1;
        rst = 1'b1;
        #1;
        hold = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(div == 3'b000, "R1", int'(div), 0);
        phase_tag = "R5";
        rst = 1'b0;
        first_edge(2, "R5");

        repeat (20) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule